// File: doc/BRIEF.md
# Bus-watch debug trigger controller

The block sits beside a CPU bus and watches each valid access (16-bit address plus a read/write strobe). Two address comparators, A and B, each compare the bus address with a programmed value. Each comparator can also be limited to reads only or to writes only. The trigger is the OR of the two comparator hits. An 8-bit control register turns the block on, arms a run, enables the break request and selects the break type. Software can read and write this register at any time.

While a run is armed, bus addresses go into an 8-entry trace FIFO. A mode input chooses between two ways of running:

- **End trace:** every valid access is stored, and the oldest entry is overwritten. The run ends on the trigger, and the break is requested in that same cycle.
- **Begin trace:** storing starts at the trigger. The run ends, and the break is requested, when the eighth entry is written.

When the run ends, both the arm bit and the armed flag clear. After that, software drains the FIFO, oldest entry first.

Top module: `bus_trigger_ctl`

## Requirements
- R1: The control register reads back bits [7] enable, [6] arm, [5] tag select, [4] break enable, [3] direction value A, [2] direction enable A, [1] direction value B, [0] direction enable B. All bits are 0 after reset, and a write is visible from the next cycle.
- R2: While `secure` is 1, a write leaves the enable bit at 0. The other written bits are stored as given.
- R3: A write with arm=1 and the resulting enable=1 sets the arm bit and `run_armed`. If the write has arm=1 but enable=0, the arm bit is stored but `run_armed` stays 0.
- R4: A write with arm=0 or enable=0 clears `run_armed`. After that, triggers produce no break and no FIFO entries.
- R5: When direction enable for a comparator is 0, that comparator ignores `bus_rd`. When it is 1, the comparator matches only on reads if the direction value is 1, and only on writes if the direction value is 0.
- R6: In end-trace mode (`trace_begin`=0), an armed run stores every valid access. `brk_req` is high combinationally in the trigger cycle for exactly one cycle. From the next cycle, the arm bit and `run_armed` read 0. The FIFO then holds the last 8 addresses, with the trigger address newest.
- R7: In begin-trace mode (`trace_begin`=1), nothing is stored before the trigger. From the trigger access onward, every valid access is stored. `brk_req` pulses in the cycle the eighth entry is written, and that cycle ends the run.
- R8: With break enable=0, a run still stores entries and still completes, but `brk_req` stays 0.
- R9: `brk_tag` equals tag select during a `brk_req` pulse and is 0 at all other times.
- R10: A register write in the same cycle as run completion wins. If it arms, `run_armed` stays 1.
- R11: `trace_pop` removes the oldest entry only while no run is active. `trace_data` always shows the oldest entry.
- R12: Arming clears the FIFO, so `trace_cnt` becomes 0. `trace_cnt` never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| secure | input | 1 | Blocks setting the enable bit |
| trace_begin | input | 1 | 1 = begin-trace, 0 = end-trace |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| run_armed | output | 1 | Armed flag of the current run |
| cmp_a_addr | input | 16 | Comparator A address |
| cmp_b_addr | input | 16 | Comparator B address |
| bus_valid | input | 1 | Bus access present |
| bus_addr | input | 16 | Bus access address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| brk_req | output | 1 | Single-cycle break request |
| brk_tag | output | 1 | 1 = tag-type break, 0 = force-type |
| trace_pop | input | 1 | Remove oldest trace entry |
| trace_data | output | 16 | Oldest trace entry |
| trace_cnt | output | 4 | Number of stored entries |

## Verification
A wrong armed flag or begin-trace start state shows up at the ports within one bus access. It appears as a missing or extra `brk_req` pulse, or as `trace_cnt` counting when it should not. Write-pointer or count errors stay hidden until the FIFO is drained after the run. At that point the popped address order exposes them, one entry per pop. Comparator qualifier faults appear in the very cycle of the access, because the break output is combinational from the bus.

// File: rtl/bus_trigger_ctl.sv
module bus_trigger_ctl #(
  parameter int AW = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          secure,
  input  logic          trace_begin,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          run_armed,
  input  logic [AW-1:0] cmp_a_addr,
  input  logic [AW-1:0] cmp_b_addr,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  output logic          brk_req,
  output logic          brk_tag,
  input  logic          trace_pop,
  output logic [AW-1:0] trace_data,
  output logic [$clog2(DEPTH+1)-1:0] trace_cnt
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [7:0]    ctl;
  logic          armf, started;
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire en_w  = reg_wdata[7] & ~secure;
  wire arm_w = reg_wdata[6] & en_w;
  wire rearm = reg_we & arm_w;
  wire act   = armf & ctl[7];

  wire hit_a = bus_valid && bus_addr == cmp_a_addr && (!ctl[2] || bus_rd == ctl[3]);
  wire hit_b = bus_valid && bus_addr == cmp_b_addr && (!ctl[0] || bus_rd == ctl[1]);
  wire trig  = hit_a | hit_b;
  wire cap   = act && bus_valid && (!trace_begin || started || trig);
  wire done  = act && (trace_begin ? (cap && cnt == LAST) : trig);
  wire pop_ok = trace_pop && !act && cnt != '0;

  assign brk_req   = done & ctl[4];
  assign brk_tag   = brk_req & ctl[5];
  assign reg_rdata = ctl;
  assign run_armed = armf;
  assign trace_cnt = cnt;
  assign trace_data = mem[rp];

  always_comb begin
    int t;
    t = int'(wp) + DEPTH - int'(cnt);
    if (t >= DEPTH) t = t - DEPTH;
    rp = PW'(t);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      armf    <= 1'b0;
      started <= 1'b0;
    end else begin
      if (reg_we) begin
        ctl  <= {en_w, reg_wdata[6:0]};
        armf <= arm_w;
      end else if (done) begin
        ctl[6] <= 1'b0;
        armf   <= 1'b0;
      end
      if (rearm || !act || done) started <= 1'b0;
      else if (cap)              started <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      cnt <= '0;
    end else if (rearm) begin
      wp  <= '0;
      cnt <= '0;
    end else if (cap) begin
      wp  <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      cnt <= (cnt == FULL) ? cnt : cnt + 1'b1;
    end else if (pop_ok) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (cap && !rearm) mem[wp] <= bus_addr;

  // R2
  a_r2_secure_blocks_en: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && secure |=> !reg_rdata[7]);
  // R4
  a_r4_stop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && !reg_wdata[6] |=> !run_armed);
  // R6
  a_r6_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req && !reg_we |=> !run_armed && !reg_rdata[6]);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req && !reg_we |=> !brk_req);
  // R9
  a_r9_tag_needs_brk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_tag |-> brk_req);
  // R10
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_wdata[7] && reg_wdata[6] && !secure |=> run_armed);
  // R11
  a_r11_pop_held: assert property (@(posedge clk) disable iff (!rst_n)
    run_armed && reg_rdata[7] && trace_pop && !bus_valid && !reg_we |=> $stable(trace_cnt));
  // R12
  a_r12_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    trace_cnt <= FULL);
endmodule

// File: tb/test_bus_trigger_ctl.sv
module test_bus_trigger_ctl;
  logic clk = 0, rst_n = 0, secure = 0, trace_begin = 0, reg_we = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic run_armed, bus_valid = 0, bus_rd = 0, brk_req, brk_tag, trace_pop = 0;
  logic [15:0] cmp_a_addr = 16'hFFFF, cmp_b_addr = 16'hFFFF, bus_addr = 0, trace_data;
  logic [3:0] trace_cnt;
  logic s_req, s_tag;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  bus_trigger_ctl i_bus_trigger_ctl (.*);

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] a, input logic rd);
    bus_valid = 1; bus_addr = a; bus_rd = rd;
    #2; s_req = brk_req; s_tag = brk_tag;
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic pop_chk(input logic [15:0] exp, input string what);
    chk(trace_data == exp, what, trace_data, exp);
    trace_pop = 1; @(negedge clk); trace_pop = 0;
  endtask

  task automatic t_reset;
    chk(reg_rdata == 0, "R1 reset reg", reg_rdata, 0);
    chk(run_armed == 0, "R3 reset armed", run_armed, 0);
    chk(trace_cnt == 0, "R12 reset cnt", trace_cnt, 0);
    chk(brk_req == 0, "R6 reset brk", brk_req, 0);
  endtask

  task automatic t_regs;
    wr(8'h3F);
    chk(reg_rdata == 8'h3F, "R1 readback", reg_rdata, 8'h3F);
    chk(run_armed == 0, "R3 arm without enable", run_armed, 0);
    wr(8'h00);
    secure = 1; wr(8'hA5);
    chk(reg_rdata == 8'h25, "R2 secure write", reg_rdata, 8'h25);
    secure = 0; wr(8'h80);
    chk(reg_rdata == 8'h80, "R2 enable unsecured", reg_rdata, 8'h80);
    wr(8'h00);
  endtask

  task automatic t_end;
    trace_begin = 0; cmp_a_addr = 16'h1234;
    wr(8'hD0);
    chk(run_armed == 1, "R3 armed", run_armed, 1);
    chk(trace_cnt == 0, "R12 cleared on arm", trace_cnt, 0);
    for (int i = 0; i < 10; i++) begin
      cyc(16'h0100 + 16'(i), 1);
      chk(s_req == 0, "R6 no early brk", s_req, 0);
    end
    chk(trace_cnt == 8, "R12 cnt saturates", trace_cnt, 8);
    cyc(16'h1234, 0);
    chk(s_req == 1, "R6 brk at trigger", s_req, 1);
    chk(s_tag == 0, "R9 force type", s_tag, 0);
    chk(run_armed == 0, "R6 disarmed", run_armed, 0);
    chk(reg_rdata == 8'h90, "R6 arm bit cleared", reg_rdata, 8'h90);
    cyc(16'h1234, 0);
    chk(s_req == 0, "R6 no brk after run", s_req, 0);
    for (int i = 3; i < 10; i++) pop_chk(16'h0100 + 16'(i), "R6 fifo order");
    pop_chk(16'h1234, "R6 trigger newest");
    chk(trace_cnt == 0, "R11 drained", trace_cnt, 0);
    cmp_a_addr = 16'hFFFF;
  endtask

  task automatic t_dir;
    cmp_a_addr = 16'h2000;
    wr(8'hDC);
    cyc(16'h2000, 0);
    chk(s_req == 0, "R5 A read-only rejects write", s_req, 0);
    cyc(16'h2000, 1);
    chk(s_req == 1, "R5 A read-only takes read", s_req, 1);
    cmp_a_addr = 16'hFFFF; cmp_b_addr = 16'h3000;
    wr(8'hD1);
    cyc(16'h3000, 1);
    chk(s_req == 0, "R5 B write-only rejects read", s_req, 0);
    cyc(16'h3000, 0);
    chk(s_req == 1, "R5 B write-only takes write", s_req, 1);
    wr(8'hD0);
    cyc(16'h3000, 1);
    chk(s_req == 1, "R5 B unqualified takes read", s_req, 1);
    cmp_b_addr = 16'hFFFF;
  endtask

  task automatic t_tag;
    cmp_a_addr = 16'h0042;
    wr(8'hF0);
    cyc(16'h0042, 1);
    chk(s_req == 1 && s_tag == 1, "R9 tag type", {s_req, s_tag}, 2'b11);
    wr(8'hE0);
    cyc(16'h0042, 1);
    chk(s_req == 0, "R8 no brk without enable", s_req, 0);
    chk(s_tag == 0, "R9 tag gated", s_tag, 0);
    chk(run_armed == 0, "R8 run completes", run_armed, 0);
    chk(trace_cnt == 1, "R8 entry stored", trace_cnt, 1);
    cmp_a_addr = 16'hFFFF;
  endtask

  task automatic t_begin;
    trace_begin = 1; cmp_a_addr = 16'h4000;
    wr(8'hD0);
    for (int i = 0; i < 3; i++) cyc(16'h0900, 0);
    chk(trace_cnt == 0, "R7 nothing before trigger", trace_cnt, 0);
    cyc(16'h4000, 1);
    chk(s_req == 0, "R7 no brk at trigger", s_req, 0);
    chk(trace_cnt == 1, "R7 trigger stored", trace_cnt, 1);
    trace_pop = 1; @(negedge clk); trace_pop = 0;
    chk(trace_cnt == 1, "R11 pop ignored while armed", trace_cnt, 1);
    for (int i = 0; i < 6; i++) begin
      cyc(16'h0500 + 16'(i), 0);
      chk(s_req == 0, "R7 no brk before full", s_req, 0);
    end
    cyc(16'h0506, 0);
    chk(s_req == 1, "R7 brk at full", s_req, 1);
    chk(run_armed == 0, "R7 run ends", run_armed, 0);
    chk(trace_cnt == 8, "R7 full", trace_cnt, 8);
    pop_chk(16'h4000, "R11 oldest first");
    for (int i = 0; i < 7; i++) pop_chk(16'h0500 + 16'(i), "R7 order");
    trace_begin = 0; cmp_a_addr = 16'hFFFF;
  endtask

  task automatic t_stop;
    cmp_a_addr = 16'h7000;
    wr(8'hD0); wr(8'h90);
    chk(run_armed == 0, "R4 arm=0 stops", run_armed, 0);
    cyc(16'h7000, 0);
    chk(s_req == 0, "R4 no brk", s_req, 0);
    chk(trace_cnt == 0, "R4 no capture", trace_cnt, 0);
    wr(8'hD0); wr(8'h50);
    chk(run_armed == 0, "R4 enable=0 stops", run_armed, 0);
    cyc(16'h7000, 0);
    chk(s_req == 0, "R4 no brk disabled", s_req, 0);
  endtask

  task automatic t_prio;
    wr(8'hD0);
    cyc(16'h1111, 0);
    bus_valid = 1; bus_addr = 16'h7000; bus_rd = 0; reg_we = 1; reg_wdata = 8'hD0;
    #2; s_req = brk_req;
    @(negedge clk); bus_valid = 0; reg_we = 0;
    chk(s_req == 1, "R10 brk still issued", s_req, 1);
    chk(run_armed == 1, "R10 write wins", run_armed, 1);
    chk(reg_rdata == 8'hD0, "R10 arm bit kept", reg_rdata, 8'hD0);
    chk(trace_cnt == 0, "R12 rearm clears", trace_cnt, 0);
    wr(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_regs; t_end; t_dir; t_tag; t_begin; t_stop; t_prio;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule